// File: doc/BRIEF.md
# Separate-I/O Static RAM Emulation

This block models a word-organised static RAM whose input and output data buses are separate. All inputs are sampled on a fast system clock. A write is defined by the interval during which the active-low select and the active-low write strobe are both low. The write is committed when that interval ends, whichever strobe rises first. The address and data committed are those seen on the last sampled cycle of the interval. Reads take place while the block is selected and the write strobe is high. The result appears one clock after the inputs are sampled.

There are no real tri-state pads. The output is a data bus plus an output-enable. A mode parameter sets what the output does during a write. In follow mode, the output drives the incoming write data. In float mode, the output is disabled. While the block is deselected, a power-down flag is raised. Reset clears only the control state. It never clears the stored words, and a word that has never been written reads back as unknown.

Top module: `sio_sram_emu`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits, one word per address value. Every address keeps its own word independently of every other address.
- R2: When `sel_n` is high, nothing is written at any address, whatever `wstb_n`, `addr` and `wdata` do.
- R3: A write interval may span several cycles. Only the `addr` and `wdata` sampled on the last cycle of the interval are stored. Values from earlier cycles of the interval are not stored, and neither are values from the cycle that ends it.
- R4: A write interval ends on the first sampled cycle in which `sel_n` or `wstb_n` is high. Both ending orders store the word: the strobe rising first, or the select rising first (alone, or together with the strobe).
- R5: On a sample with `sel_n` low and `wstb_n` high, the next cycle has `rdata_oe` = 1, and `rdata` equals the word stored at the sampled `addr`.
- R6: On a sample with `sel_n` high, the next cycle has `rdata_oe` = 0.
- R7: In float mode (MODE = OUT_FLOAT), a sample with both `sel_n` and `wstb_n` low gives `rdata_oe` = 0 on the next cycle. If both strobes rise on the same sample, the output stays disabled for that cycle.
- R8: In follow mode (MODE = OUT_FOLLOW), a sample with both strobes low gives `rdata_oe` = 1 on the next cycle, and `rdata` equals the `wdata` sampled.
- R9: `pdown` is 1 in the cycle after a sample with `sel_n` high. It is 0 in the cycle after a sample with `sel_n` low.
- R10: A read may be sampled on the same cycle that ends a write. If the read is to the written address, it returns the newly written word. A read of a different address returns that address's previous word.
- R11: A sample with `rst_n` low gives `rdata_oe` = 0 and `pdown` = 1 on the next cycle. Reset leaves all stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data bus |
| sel_n | input | 1 | Active-low select |
| wstb_n | input | 1 | Active-low write strobe |
| rdata | output | DATA_W | Read data bus (meaningful when rdata_oe = 1) |
| rdata_oe | output | 1 | Output drive enable; 0 models high impedance |
| pdown | output | 1 | Power-down flag, high while deselected |

## Verification
The bench builds two copies of the block with ADDR_W = 6 and DATA_W = 4, one in float mode and one in follow mode. Both copies are fed the same stimulus. With only 64 words, every address can be written and then read back, against a reference array whose contents come from a simple arithmetic pattern. The small depth also makes it cheap to check, at every location, that deselected writes and resets leave the array intact. Direct sequences cover both ending orders of a write, multi-cycle intervals whose address and data change along the way, and a read sampled in the cycle a write ends.

// File: rtl/sio_sram_pkg.sv
// Shared definitions for the separate-I/O RAM emulation.
// Assumes: nothing; types only.
package sio_sram_pkg;
    // Output behaviour while a write interval is open.
    typedef enum logic {
        OUT_FLOAT  = 1'b0,   // output disabled during a write
        OUT_FOLLOW = 1'b1    // output drives the write data during a write
    } out_mode_e;
endpackage

// File: rtl/sio_wr_track.sv
// Write-interval tracker.
// Watches the two active-low strobes. The interval is open while both are low.
// It records the address and data of every open sample, and pulses `commit`
// on the first sample after the interval closes.
// Assumes: inputs are already synchronous to clk.
module sio_wr_track #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wstb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_data
);
    logic              open_now;
    logic              open_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Interval open when both strobes are low in this sample.
    assign open_now = ~sel_n & ~wstb_n;

    // Remember whether the previous sample was inside an interval.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_now;
    end

    // Hold address and data from the latest open sample.
    always_ff @(posedge clk) begin
        if (open_now) begin
            addr_q <= addr;
            data_q <= wdata;
        end
    end

    // Commit on the first closed sample after one or more open ones.
    assign commit = open_q & ~open_now;
    assign c_addr = addr_q;
    assign c_data = data_q;
endmodule

// File: rtl/sio_store.sv
// Word storage array with one write port and one combinational read port.
// Contents are never reset. Unwritten words read as unknown in simulation.
// Assumes: at most one write per clock.
module sio_store #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a committed word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Asynchronous read of the addressed word.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sio_out_stage.sv
// Output register: chooses read data, forwarded commit data, follow data or a
// disabled output, and registers the power-down flag.
// Assumes: `commit`, `c_addr` and `c_data` come from the write tracker in the
// same cycle.
module sio_out_stage #(
    parameter int                     ADDR_W = 12,
    parameter int                     DATA_W = 4,
    parameter sio_sram_pkg::out_mode_e MODE  = sio_sram_pkg::OUT_FLOAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wstb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              commit,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              pdown
);
    localparam bit FOLLOW = (MODE == sio_sram_pkg::OUT_FOLLOW);

    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] wr_view;
    logic              wr_drive;

    // Read word, forwarding a word committed in this same cycle.
    assign rd_word = (commit && (c_addr == addr)) ? c_data : arr_data;

    // Variant choice for the output during a write interval.
    generate
        if (FOLLOW) begin : g_follow
            assign wr_drive = 1'b1;
            assign wr_view  = wdata;
        end else begin : g_float
            assign wr_drive = 1'b0;
            assign wr_view  = arr_data;
        end
    endgenerate

    // Register the output data, its enable and the power-down flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
            pdown    <= 1'b1;
        end else if (sel_n) begin
            rdata_oe <= 1'b0;
            pdown    <= 1'b1;
        end else if (!wstb_n) begin
            rdata_oe <= wr_drive;
            rdata    <= wr_view;
            pdown    <= 1'b0;
        end else begin
            rdata_oe <= 1'b1;
            rdata    <= rd_word;
            pdown    <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_sram_emu.sv
// Top of the separate-I/O static RAM emulation.
// Ties the write tracker, the storage array and the output stage together.
// Assumes: all inputs are synchronous to clk. Outputs lag inputs by one cycle.
module sio_sram_emu #(
    parameter int                     ADDR_W = 12,
    parameter int                     DATA_W = 4,
    parameter sio_sram_pkg::out_mode_e MODE  = sio_sram_pkg::OUT_FLOAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sel_n,
    input  logic              wstb_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              pdown
);
    logic              wr_commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] arr_data;

    sio_wr_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n),
        .addr(addr), .wdata(wdata),
        .commit(wr_commit), .c_addr(wr_addr), .c_data(wr_data)
    );

    sio_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .wr_en(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(addr), .rd_data(arr_data)
    );

    sio_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE(MODE)) u_out (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n),
        .addr(addr), .wdata(wdata), .arr_data(arr_data),
        .commit(wr_commit), .c_addr(wr_addr), .c_data(wr_data),
        .rdata(rdata), .rdata_oe(rdata_oe), .pdown(pdown)
    );
endmodule

// File: rtl/sio_sram_chk.sv
// Property checker for sio_sram_emu, attached by bind below.
// Assumes: synchronous active-low reset. Properties are off while reset is low.
module sio_sram_chk #(
    parameter int                     DATA_W = 4,
    parameter sio_sram_pkg::out_mode_e MODE  = sio_sram_pkg::OUT_FLOAT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              wstb_n,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic              pdown,
    input logic              wr_commit
);
    assert_deselect_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !rdata_oe);

    assert_pdown_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> pdown);

    assert_pdown_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |=> !pdown);

    assert_read_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wstb_n) |=> rdata_oe);

    assert_commit_after_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(!sel_n && !wstb_n));

    generate
        if (MODE == sio_sram_pkg::OUT_FOLLOW) begin : g_follow
            assert_follow_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!sel_n && !wstb_n) |=> (rdata_oe && rdata == $past(wdata)));
        end else begin : g_float
            assert_float_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!sel_n && !wstb_n) |=> !rdata_oe);
        end
    endgenerate
endmodule

bind sio_sram_emu sio_sram_chk #(.DATA_W(DATA_W), .MODE(MODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .pdown(pdown), .wr_commit(wr_commit)
);

// File: tb/sio_sram_emu_test.sv
// Bench: two copies (float and follow mode) on a 64-word array, shared stimulus.
module sio_sram_emu_test;
    localparam int AW = 6;
    localparam int DW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          sel_n = 1'b1;
    logic          wstb_n = 1'b1;
    logic [DW-1:0] rd_f, rd_t;
    logic          oe_f, oe_t, pd_f, pd_t;

    int n_run  = 0;
    int n_fail = 0;
    int exp_mem [N];

    always #2 clk = ~clk;

    sio_sram_emu #(.ADDR_W(AW), .DATA_W(DW), .MODE(sio_sram_pkg::OUT_FLOAT)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .sel_n(sel_n),
        .wstb_n(wstb_n), .rdata(rd_f), .rdata_oe(oe_f), .pdown(pd_f));

    sio_sram_emu #(.ADDR_W(AW), .DATA_W(DW), .MODE(sio_sram_pkg::OUT_FOLLOW)) uut_fw (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .sel_n(sel_n),
        .wstb_n(wstb_n), .rdata(rd_t), .rdata_oe(oe_t), .pdown(pd_t));

    function automatic int pat(int a, int k);
        return (a * 7 + k * 3 + 1) & 15;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one sample; returns at the next falling edge, outputs settled.
    task automatic drive(bit s, bit w, int a, int d);
        sel_n  = s;
        wstb_n = w;
        addr   = AW'(a);
        wdata  = DW'(d);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_both(int a, string tag);
        drive(1'b0, 1'b1, a, 0);
        chk(oe_f && rd_f === DW'(exp_mem[a]), tag, int'(rd_f), exp_mem[a]);
        chk(oe_t && rd_t === DW'(exp_mem[a]), tag, int'(rd_t), exp_mem[a]);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R11: reset state
        drive(1, 1, 0, 0);
        drive(1, 1, 0, 0);
        chk(!oe_f && !oe_t, "R11 reset oe", int'(oe_f), 0);
        chk(pd_f && pd_t, "R11 reset pdown", int'(pd_f), 1);
        rst_n = 1'b1;

        // R1 R7 R8 R9 R10: write every word, read it back in the ending cycle
        for (int a = 0; a < N; a++) begin
            drive(0, 0, a, pat(a, 0));
            chk(!oe_f, "R7 float during write", int'(oe_f), 0);
            chk(oe_t && rd_t == DW'(pat(a, 0)), "R8 follow data", int'(rd_t), pat(a, 0));
            chk(!pd_f && !pd_t, "R9 selected pdown", int'(pd_f), 0);
            drive(0, 1, a, 15 - pat(a, 0));
            chk(oe_f && rd_f == DW'(pat(a, 0)), "R10 forward float", int'(rd_f), pat(a, 0));
            chk(oe_t && rd_t == DW'(pat(a, 0)), "R10 forward follow", int'(rd_t), pat(a, 0));
            exp_mem[a] = pat(a, 0);
        end

        // R1 R5: full read sweep
        for (int a = 0; a < N; a++) read_both(a, "R1 R5 sweep");

        // R3: multi-cycle interval, only last sample stored
        drive(0, 0, 5, 1);
        drive(0, 0, 9, 2);
        drive(0, 0, 12, 3);
        drive(0, 1, 12, 0);
        exp_mem[12] = 3;
        chk(oe_f && rd_f == 4'd3, "R3 last sample", int'(rd_f), 3);
        read_both(5, "R3 early addr untouched");
        read_both(9, "R3 mid addr untouched");

        // R3 R10: ending cycle carries other address/data
        drive(0, 0, 20, 10);
        drive(0, 1, 21, 5);
        chk(oe_f && rd_f == DW'(exp_mem[21]), "R10 other addr old", int'(rd_f), exp_mem[21]);
        exp_mem[20] = 10;
        read_both(20, "R3 end sample ignored");

        // R4 R7 R6 R9: both strobes rise together
        drive(0, 0, 30, 12);
        drive(1, 1, 30, 3);
        chk(!oe_f && !oe_t, "R7 R6 joint rise off", int'(oe_f), 0);
        chk(pd_f && pd_t, "R9 deselect pdown", int'(pd_f), 1);
        exp_mem[30] = 12;
        read_both(30, "R4 joint rise stored");

        // R4: select rises while strobe stays low
        drive(0, 0, 31, 6);
        drive(1, 0, 31, 9);
        chk(!oe_f && !oe_t, "R6 deselect off", int'(oe_t), 0);
        exp_mem[31] = 6;
        read_both(31, "R4 select ends write");

        // R2: deselected write attempts ignored
        for (int a = 40; a < 48; a++) begin
            drive(1, 0, a, 15 - exp_mem[a]);
            chk(!oe_f && !oe_t && pd_f, "R2 R6 deselected", int'(oe_f), 0);
        end
        drive(1, 1, 0, 0);
        for (int a = 40; a < 48; a++) read_both(a, "R2 no write when deselected");

        // R11: reset keeps array contents
        rst_n = 1'b0;
        drive(1, 1, 0, 0);
        drive(1, 1, 0, 0);
        chk(!oe_f && pd_f, "R11 reset again", int'(oe_f), 0);
        rst_n = 1'b1;
        for (int a = 0; a < N; a++) read_both(a, "R11 array kept");

        finish_run();
    end
endmodule